// File: doc/BRIEF.md
# Serial Link Request Transmitter

This block sits on the link side of a PHY-link connection and turns one parallel request into a framed serial stream on a single wire. The stream leaves one bit per clock, most significant bit first. Each frame starts with a 1, carries a 4-bit kind code, then the payload for that kind, and ends with a 0. Between frames the wire rests low.

A request is offered with a kind code, a register address, a data byte and a 5-bit bus payload. Only the fields that the kind uses go into the frame. A ready/valid handshake takes one request at a time. Ready stays low while a frame is on the wire. Ready is also low while a reserved kind code is offered, so such a request is never taken.

Top module: `lreq_tx`

## Requirements
- R1: With no frame in progress, `ser_out` is 0.
- R2: In the clock cycle after a request is taken (`req_valid` and `req_ready` both high at a rising edge), `ser_out` is 1. This is the start bit.
- R3: Stream bits 1 to 4 carry `req_kind`, bit 3 of the code first.
- R4: Kind codes 0001, 0010, 0011, 0100, 0110, 0111 and 1000 are bus requests. Their frame is 11 bits: start bit, kind, `req_bus[4:0]` sent MSB first, stop bit.
- R5: Kind 1010 (register read) sends a 10-bit frame: start bit, kind, `req_addr[3:0]` sent MSB first, stop bit.
- R6: Kind 1011 (register write) sends an 18-bit frame: start bit, kind, `req_addr[3:0]`, `req_data[7:0]`, stop bit, each field sent MSB first.
- R7: Kinds 1100, 1101 and 1110 (link notifications) send a 6-bit frame: start bit, kind, stop bit.
- R8: Kind codes 0000, 0101, 1001 and 1111 are reserved. While one of them is offered, `req_ready` is low and nothing is sent.
- R9: The last bit of every frame is 0. After a request is taken, `req_ready` stays low for exactly as many cycles as the frame has bits. A new request can be taken in the very next cycle.
- R10: Input fields that a kind does not use have no effect on its frame.
- R11: While `rst_n` is low, and right after it is released, `ser_out` is 0 and `req_ready` is high for a legal kind code. Asserting reset in the middle of a frame stops that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The offered request can be taken |
| req_kind | input | 4 | Request kind code |
| req_addr | input | 4 | Register address (read and write) |
| req_data | input | 8 | Write data (write only) |
| req_bus | input | 5 | Bus request payload |
| ser_out | output | 1 | Serial request line |

## Verification
When a request is taken at rising edge E0, bit k of its frame appears on `ser_out` after edge E0+k. For a frame of L bits, `req_ready` rises again after edge E0+L. The bench samples on the falling edge that follows each rising edge and compares one frame bit each time. At the falling edge after E0+L it expects the line to be idle and ready to be high. The next vector is offered in that same half-cycle, so every frame is checked back to back with the previous one.

// File: rtl/lreq_tx.sv
module lreq_tx #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [BW-1:0] req_bus,
  output logic          ser_out
);
  localparam int KW      = 4;
  localparam int FW      = 2 + KW + AW + DW;
  localparam int CW      = $clog2(FW + 1);
  localparam int BUS_LEN = 2 + KW + BW;
  localparam int RD_LEN  = 2 + KW + AW;
  localparam int NTF_LEN = 2 + KW;

  logic [FW-1:0] sh, frame;
  logic [CW-1:0] cnt, len;
  logic          legal, busy, take;

  always_comb begin
    legal = 1'b1;
    len   = '0;
    frame = '0;
    case (req_kind)
      4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0110, 4'b0111, 4'b1000: begin
        len   = CW'(BUS_LEN);
        frame = FW'({1'b1, req_kind, req_bus, 1'b0}) << (FW - BUS_LEN);
      end
      4'b1010: begin
        len   = CW'(RD_LEN);
        frame = FW'({1'b1, req_kind, req_addr, 1'b0}) << (FW - RD_LEN);
      end
      4'b1011: begin
        len   = CW'(FW);
        frame = {1'b1, req_kind, req_addr, req_data, 1'b0};
      end
      4'b1100, 4'b1101, 4'b1110: begin
        len   = CW'(NTF_LEN);
        frame = FW'({1'b1, req_kind, 1'b0}) << (FW - NTF_LEN);
      end
      default: legal = 1'b0;
    endcase
  end

  assign busy      = (cnt != '0);
  assign req_ready = !busy && legal;
  assign take      = req_valid && req_ready;
  assign ser_out   = busy && sh[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (take) begin
      cnt <= len;
      sh  <= frame;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      sh  <= sh << 1;
    end
  end
endmodule

module lreq_tx_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [3:0]    req_kind,
  input logic          ser_out,
  input logic [CW-1:0] cnt
);
  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ser_out);

  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ser_out);

  // R3
  kind_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##1 (ser_out == $past(req_kind[3], 2)));

  // R8
  reserved_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind inside {4'b0000, 4'b0101, 4'b1001, 4'b1111}) |-> !req_ready);

  // R9
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(1)) |-> !ser_out);
endmodule

bind lreq_tx lreq_tx_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .ser_out(ser_out), .cnt(cnt)
);

// File: tb/lreq_tx_test.sv
`timescale 1ns/1ps
module lreq_tx_test;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [3:0] req_kind = 4'b0001, req_addr = '0;
  logic [7:0] req_data = '0;
  logic [4:0] req_bus = '0;
  logic req_ready, ser_out;
  int checks = 0, fails = 0;

  lreq_tx uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data), .req_bus(req_bus),
    .ser_out(ser_out));

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [3:0]  k;
    logic [3:0]  a;
    logic [7:0]  d;
    logic [4:0]  b;
    logic [4:0]  len;
    logic [17:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'b0001, 4'h3, 8'h77, 5'b10110, 5'd11, 18'b10001101100},
    '{4'b0100, 4'h0, 8'h00, 5'b00001, 5'd11, 18'b10100000010},
    '{4'b1000, 4'hF, 8'hFF, 5'b11111, 5'd11, 18'b11000111110},
    '{4'b1010, 4'b1001, 8'hFF, 5'h1F, 5'd10, 18'b1101010010},
    '{4'b1011, 4'b0110, 8'hA5, 5'h1F, 5'd18, 18'b110110110101001010},
    '{4'b1100, 4'hF, 8'hFF, 5'h1F, 5'd6, 18'b111000},
    '{4'b1110, 4'h0, 8'h00, 5'h00, 5'd6, 18'b111100},
    '{4'b0111, 4'h5, 8'h3C, 5'b01010, 5'd11, 18'b10111010100},
    '{4'b1101, 4'hA, 8'h5A, 5'h15, 5'd6, 18'b111010}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] k);
    case (k)
      4'b1010: return "R5/R10 read frame";
      4'b1011: return "R6 write frame";
      4'b1100, 4'b1101, 4'b1110: return "R7/R10 notify frame";
      default: return "R4 bus frame";
    endcase
  endfunction

  task automatic send(input vec_t v);
    req_kind = v.k; req_addr = v.a; req_data = v.d; req_bus = v.b; req_valid = 1'b1;
    chk("R9 ready before take", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < int'(v.len); i++) begin
      if (i == 0) chk("R2 start bit", ser_out, 1);
      else if (i < 5) chk("R3 kind bit", ser_out, v.exp[v.len - 1 - i]);
      else if (i == int'(v.len) - 1) chk("R9 stop bit", ser_out, 0);
      else chk(tag_of(v.k), ser_out, v.exp[v.len - 1 - i]);
      chk("R9 ready low in frame", req_ready, 0);
      @(negedge clk);
    end
    chk("R1 idle after frame", ser_out, 0);
    chk("R9 ready after frame", req_ready, 1);
  endtask

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R11 reset ser_out", ser_out, 0);
    chk("R11 reset ready", req_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after reset ser_out", ser_out, 0);
    chk("R11 after reset ready", req_ready, 1);

    for (int n = 0; n < NV; n++) send(VECS[n]);

    foreach (VECS[n]) begin end
    begin
      logic [3:0] rsv [4] = '{4'b0000, 4'b0101, 4'b1001, 4'b1111};
      for (int r = 0; r < 4; r++) begin
        req_kind = rsv[r]; req_valid = 1'b1;
        @(negedge clk);
        chk("R8 reserved ready", req_ready, 0);
        for (int c = 0; c < 4; c++) begin
          @(negedge clk);
          chk("R8 reserved no output", ser_out, 0);
        end
      end
      req_valid = 1'b0;
    end

    req_kind = 4'b1011; req_addr = 4'hF; req_data = 8'hFF; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 mid-frame reset ser_out", ser_out, 0);
    chk("R11 mid-frame reset ready", req_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R1 idle after abort", ser_out, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule